// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a synchronous request port and an external 1M x 8 asynchronous static RAM. Each accepted request is a single-byte read or write. The controller turns it into a strobe sequence of address, a chip-select pair, output enable and write enable. The length of every phase is a whole number of clock cycles. Each length comes from a nanosecond minimum rounded up against the clock period. The controller owns the tri-state control of the shared data bus.

A user raises `req` while `busy` is low. The controller latches the operands on that edge. A read ends with a one-cycle `rvalid` pulse with the byte on `rdata`. A write ends with a one-cycle `wdone` pulse. Between accesses both selects sit at their inactive levels, so the RAM is in standby. A write that follows a read waits out the time the RAM may still drive the bus after its outputs are released.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and until the first request, `ram_cs1_n`=1, `ram_cs2`=0, `ram_oe_n`=1, `ram_we_n`=1, `busy`=0, `rvalid`=0 and `wdone`=0.
- R2: A request with `req_we`=0 is a read. It is accepted at a rising edge where `req`=1 and `busy`=0. With the default timing (10 ns clock, 55 ns address access, 25 ns output-enable access, 55 ns read cycle), `rvalid` first shows high after the 6th rising edge following acceptance and lasts one cycle.
- R3: Read data is sampled no sooner than the address access time after address and selects are driven, and no sooner than the output-enable access time after `ram_oe_n` falls. `ram_oe_n` falls one cycle after the address. `rdata` equals the RAM byte at the requested address.
- R4: A request with `req_we`=1 is a write. `ram_we_n` is low for at least ceil(40 ns / period) cycles. The address and both selects are present at least 45 ns before `ram_we_n` rises. Write data is on the bus at least 20 ns before the rise. The RAM stores `req_wdata`.
- R5: `wdone` is a one-cycle pulse in the cycle `ram_we_n` returns high. When the previous access was not a read, this is the 5th rising edge after acceptance. `busy` falls one cycle later.
- R6: A write that follows a read adds a turnaround of ceil(20 ns / period) = 2 cycles, so `wdone` comes after the 7th edge. The controller starts driving at least 20 ns after the RAM's outputs were released.
- R7: While `busy` is high, `req`, `req_we`, `req_addr` and `req_wdata` are ignored. Address and write data are taken only at the accepting edge.
- R8: `ram_oe_n` and `ram_we_n` are never both low. Either one is low only while `ram_cs1_n`=0 and `ram_cs2`=1.
- R9: Whenever `busy` is low, both selects are inactive and both strobes are high. `ram_cs1_n` is always the inverse of `ram_cs2`.
- R10: The controller drives `ram_dq` from the cycle before `ram_we_n` falls until the cycle in which it rises. It releases the bus on the following edge and never drives while `ram_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress, requests ignored |
| rvalid | output | 1 | One-cycle read completion |
| rdata | output | 8 | Captured read byte |
| wdone | output | 1 | One-cycle write completion |
| ram_addr | output | 20 | RAM address |
| ram_cs1_n | output | 1 | Active-low chip select |
| ram_cs2 | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_dq | inout | 8 | Bidirectional data bus |

## Verification
Read data capture and the release of output enable and the selects happen on the same clock edge. The bench RAM model provokes this case: it puts a poison byte on the bus until both access windows have elapsed, and again for 20 ns after its outputs turn off. A capture taken one cycle early, or any result that depends on ordering at the release edge, shows up as a wrong `rdata`. The second coincidence is a completion pulse arriving while the user still holds `req` high with new operands. It is judged by the model's access counters and by checking that `ram_addr` holds the first address for the whole access.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPT,
    ST_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_END
  } ctl_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_span_timer.sv
`timescale 1ns/1ps
module asram_span_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq_fsm.sv
`timescale 1ns/1ps
module asram_seq_fsm
  import asram_pkg::*;
#(
  parameter int RD_WAIT_C  = 5,
  parameter int WR_PULSE_C = 4,
  parameter int TURN_C     = 2,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             tmr_expired,
  output ctl_state_e       state_q,
  output ctl_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  logic last_rd_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (!req_we) begin
            state_d = ST_RD_SETUP;
          end else if (last_rd_q) begin
            state_d  = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TURN_C - 1);
          end else begin
            state_d = ST_WR_SETUP;
          end
        end
      end
      ST_RD_SETUP: begin
        state_d  = ST_RD_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RD_WAIT_C - 1);
      end
      ST_RD_WAIT:  if (tmr_expired) state_d = ST_RD_CAPT;
      ST_RD_CAPT:  state_d = ST_IDLE;
      ST_TURN:     if (tmr_expired) state_d = ST_WR_SETUP;
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WR_PULSE_C - 1);
      end
      ST_WR_PULSE: if (tmr_expired) state_d = ST_WR_END;
      ST_WR_END:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Remembers whether the RAM drove the bus in the last access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd_q <= 1'b0;
    end else if (state_q == ST_RD_CAPT) begin
      last_rd_q <= 1'b1;
    end else if (state_q == ST_WR_SETUP) begin
      last_rd_q <= 1'b0;
    end
  end

endmodule

// File: rtl/asram_pin_regs.sv
`timescale 1ns/1ps
module asram_pin_regs
  import asram_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  ctl_state_e        state_q,
  input  ctl_state_e        state_d,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              cs1_n,
  output logic              cs2,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              wdone
);

  logic sel_d, oe_d, we_d, drv_d, capture;

  always_comb begin
    sel_d   = state_d inside {ST_RD_SETUP, ST_RD_WAIT, ST_TURN,
                              ST_WR_SETUP, ST_WR_PULSE, ST_WR_END};
    oe_d    = (state_d == ST_RD_WAIT);
    we_d    = (state_d == ST_WR_PULSE);
    drv_d   = state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_END};
    capture = (state_q == ST_RD_WAIT) && (state_d == ST_RD_CAPT);
  end

  // Strobes and handshake flags: registered from the next state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs1_n  <= 1'b1;
      cs2    <= 1'b0;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      dq_oe  <= 1'b0;
      rvalid <= 1'b0;
      wdone  <= 1'b0;
    end else begin
      cs1_n  <= ~sel_d;
      cs2    <= sel_d;
      oe_n   <= ~oe_d;
      we_n   <= ~we_d;
      dq_oe  <= drv_d;
      rvalid <= (state_d == ST_RD_CAPT);
      wdone  <= (state_d == ST_WR_END);
    end
  end

  // Operands: loaded only on the accepting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      ram_addr <= addr_in;
      dq_out   <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= dq_in;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 25,
  parameter int T_RC_NS   = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_AW_NS   = 45,
  parameter int T_DW_NS   = 20,
  parameter int T_WC_NS   = 55,
  parameter int T_HZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              wdone,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs1_n,
  output logic              ram_cs2,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  inout  wire  [DATA_W-1:0] ram_dq
);

  localparam int AA_C = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int OE_C = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int RC_C = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int WP_C = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int AW_C = ns_to_cyc(T_AW_NS, CLK_NS);
  localparam int DW_C = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int WC_C = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int HZ_C = ns_to_cyc(T_HZ_NS, CLK_NS);
  // Read: address at edge 0, OE falls at edge 1, capture at edge RD_SPAN.
  localparam int RD_SPAN    = imax(imax(AA_C, OE_C + 1), RC_C);
  localparam int RD_WAIT_C  = RD_SPAN - 1;
  // Write: setup cycle, pulse, end cycle.
  localparam int WR_PULSE_C = imax(imax(imax(WP_C, AW_C - 1), imax(DW_C - 1, WC_C - 2)), 1);
  localparam int TURN_C     = HZ_C;
  localparam int CNT_MAX    = imax(imax(RD_WAIT_C, WR_PULSE_C), TURN_C);
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  ctl_state_e       state_q, state_d;
  logic             tmr_load, tmr_expired, accept;
  logic [CNT_W-1:0] tmr_val;
  logic [DATA_W-1:0] dq_out;
  logic             dq_oe;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  assign busy   = (state_q != ST_IDLE);
  assign accept = req && !busy;

  asram_seq_fsm #(
    .RD_WAIT_C (RD_WAIT_C),
    .WR_PULSE_C(WR_PULSE_C),
    .TURN_C    (TURN_C),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req        (req),
    .req_we     (req_we),
    .tmr_expired(tmr_expired),
    .state_q    (state_q),
    .state_d    (state_d),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val)
  );

  asram_span_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  asram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .accept  (accept),
    .state_q (state_q),
    .state_d (state_d),
    .addr_in (req_addr),
    .wdata_in(req_wdata),
    .dq_in   (ram_dq),
    .ram_addr(ram_addr),
    .cs1_n   (ram_cs1_n),
    .cs2     (ram_cs2),
    .oe_n    (ram_oe_n),
    .we_n    (ram_we_n),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .rdata   (rdata),
    .rvalid  (rvalid),
    .wdone   (wdone)
  );

  assign ram_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rvalid,
  input logic              wdone,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              cs1_n,
  input logic              cs2,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe
);

  p_rvalid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  p_wdone_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdone |=> !wdone);

  p_we_rise_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> wdone);

  p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ram_addr));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_strobe_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> (!cs1_n && cs2));

  p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs1_n && !cs2 && oe_n && we_n));

  p_sel_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs1_n != cs2);

  p_drive_in_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  p_release_after_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |=> !dq_oe);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .busy    (busy),
  .rvalid  (rvalid),
  .wdone   (wdone),
  .ram_addr(ram_addr),
  .cs1_n   (ram_cs1_n),
  .cs2     (ram_cs2),
  .oe_n    (ram_oe_n),
  .we_n    (ram_we_n),
  .dq_oe   (dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  // Latencies at a 10 ns clock: read ceil(55/10)=6; write 1+max(4,5-1,2-1,6-2)=5;
  // read-to-write turnaround ceil(20/10)=2.
  localparam int RD_LAT = 6;
  localparam int WR_LAT = 5;
  localparam int TURN   = 2;

  logic        clk, rst_n, req, req_we;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy, rvalid, wdone;
  logic [7:0]  rdata;
  logic [19:0] ram_addr;
  logic        ram_cs1_n, ram_cs2, ram_oe_n, ram_we_n;
  wire  [7:0]  ram_dq;

  int errors = 0;
  int checks = 0;

  asram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rvalid(rvalid), .rdata(rdata), .wdone(wdone), .ram_addr(ram_addr),
    .ram_cs1_n(ram_cs1_n), .ram_cs2(ram_cs2), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_dq(ram_dq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  // ---------------- behavioural RAM model ----------------
  logic [7:0] ram_mem [logic [19:0]];
  logic [7:0] m_val;
  logic       m_drv;
  realtime    t_addr, t_oe, t_rel, t_we, t_sel, t_dchg;
  int         wr_cnt, rd_cnt;
  logic       sel_prev;

  assign ram_dq = m_drv ? m_val : 8'hzz;

  function automatic logic [7:0] mem_rd(input logic [19:0] a);
    return ram_mem.exists(a) ? ram_mem[a] : init_val(a);
  endfunction

  always @(ram_addr) t_addr = $realtime;
  always @(ram_dq)   t_dchg = $realtime;
  always @(negedge ram_oe_n) begin
    t_oe = $realtime;
    if (rst_n && !ram_cs1_n && ram_cs2) rd_cnt++;
  end
  always @(negedge ram_we_n) t_we = $realtime;
  always @(ram_cs1_n or ram_cs2) begin
    if (!ram_cs1_n && ram_cs2 && !sel_prev) t_sel = $realtime;
    sel_prev = !ram_cs1_n && ram_cs2;
  end

  // Output driver, polled off the clock edges.
  initial begin
    bit prev_on;
    bit rd_on;
    realtime now;
    m_drv = 1'b0; m_val = 8'h00; prev_on = 1'b0; t_rel = -1000.0;
    #0.5;
    forever begin
      now   = $realtime;
      rd_on = !ram_cs1_n && ram_cs2 && !ram_oe_n && ram_we_n && rst_n;
      if (prev_on && !rd_on) t_rel = now;
      prev_on = rd_on;
      if (rd_on) begin
        m_drv = 1'b1;
        m_val = ((now - t_addr >= 55.0) && (now - t_oe >= 25.0)) ? mem_rd(ram_addr) : 8'hEE;
      end else if (now - t_rel < 20.0) begin
        m_drv = 1'b1;
        m_val = 8'hEE;
      end else begin
        m_drv = 1'b0;
      end
      #1;
    end
  end

  // Write timing judged at the rising write strobe.
  always @(posedge ram_we_n) begin
    realtime now;
    now = $realtime;
    if (rst_n && !ram_cs1_n && ram_cs2) begin
      chk(now - t_we >= 40.0, "R4", "write pulse ns", longint'(now - t_we), 40);
      chk(now - t_addr >= 45.0, "R4", "address to end of write ns", longint'(now - t_addr), 45);
      chk(now - t_sel >= 45.0, "R4", "select to end of write ns", longint'(now - t_sel), 45);
      chk(now - t_dchg >= 20.0, "R4", "data setup ns", longint'(now - t_dchg), 20);
      chk((t_we - 10.0) - t_rel >= 20.0, "R6", "drive after RAM release ns",
          longint'((t_we - 10.0) - t_rel), 20);
      ram_mem[ram_addr] = ram_dq;
      wr_cnt++;
    end
  end

  // ---------------- continuous port monitors ----------------
  int ovl_bad, stby_bad;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ram_oe_n && !ram_we_n) ovl_bad++;
      if (!busy && !(ram_cs1_n && !ram_cs2 && ram_oe_n && ram_we_n)) stby_bad++;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] exp_mem [logic [19:0]];
  bit prev_rd;

  function automatic logic [7:0] exp_rd(input logic [19:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
  endfunction

  task automatic do_op(input bit w, input logic [19:0] a, input logic [7:0] d);
    int k, lat, tc;
    tc  = (w && prev_rd) ? TURN : 0;
    lat = w ? (WR_LAT + tc) : RD_LAT;
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; req_addr = ~a; req_wdata = ~d;   // R7: later changes ignored
    k = 0;
    while (!(w ? wdone : rvalid) && k < 40) begin
      if (w && k == tc) begin
        chk(ram_dq == d, "R10", "bus driven before strobe", ram_dq, d);
        chk(ram_we_n == 1'b1, "R4", "strobe high in setup", ram_we_n, 1);
      end
      if (w && k == tc + 1) chk(ram_we_n == 1'b0, "R4", "strobe low", ram_we_n, 0);
      if (k > 0) chk(ram_addr == a, "R7", "address held", ram_addr, a);
      @(negedge clk);
      k++;
    end
    if (w) begin
      chk(k == lat, prev_rd ? "R6" : "R5", "write latency", k, lat);
      exp_mem[a] = d;
    end else begin
      chk(k == lat, "R2", "read latency", k, lat);
      chk(rdata == exp_rd(a), "R3", "read data", rdata, exp_rd(a));
    end
    prev_rd = !w;
    @(negedge clk);
    chk((w ? wdone : rvalid) == 1'b0, w ? "R5" : "R2", "pulse width", w ? wdone : rvalid, 0);
    chk(busy == 1'b0, "R9", "busy released", busy, 0);
  endtask

  initial begin
    logic [19:0] a_tab [0:21];
    int wr0, rd0;
    req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0; prev_rd = 1'b0; ovl_bad = 0; stby_bad = 0;
    wr_cnt = 0; rd_cnt = 0; sel_prev = 1'b0;
    t_addr = 0.0; t_oe = 0.0; t_we = 0.0; t_sel = 0.0; t_dchg = 0.0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ram_cs1_n == 1 && ram_cs2 == 0, "R1", "selects in reset", {ram_cs1_n, ram_cs2}, 2'b10);
    chk(ram_oe_n == 1 && ram_we_n == 1, "R1", "strobes in reset", {ram_oe_n, ram_we_n}, 2'b11);
    chk(!busy && !rvalid && !wdone, "R1", "flags in reset", {busy, rvalid, wdone}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ram_cs1_n == 1 && ram_cs2 == 0 && !busy, "R1", "idle after reset",
        {ram_cs1_n, ram_cs2, busy}, 3'b100);

    for (int i = 0; i < 20; i++) a_tab[i] = 20'(1) << i;
    a_tab[20] = 20'h00000;
    a_tab[21] = 20'hFFFFF;

    // Write sweep across every address bit, then read back.
    for (int i = 0; i < 22; i++) do_op(1'b1, a_tab[i], 8'(i * 37 + 11));
    for (int i = 0; i < 22; i++) do_op(1'b0, a_tab[i], 8'h00);
    // Untouched locations.
    do_op(1'b0, 20'h55555, 8'h00);
    do_op(1'b0, 20'hAAAAA, 8'h00);
    // Read-then-write turnaround, alternating data patterns.
    for (int i = 0; i < 8; i++) begin
      do_op(1'b0, 20'h12340 + 20'(i), 8'h00);
      do_op(1'b1, 20'h12340 + 20'(i), (i % 2 == 0) ? 8'hA5 : 8'h5A);
    end
    for (int i = 0; i < 8; i++) do_op(1'b0, 20'h12340 + 20'(i), 8'h00);
    // Back-to-back writes and overwrite.
    do_op(1'b1, 20'h00FF0, 8'hFF);
    do_op(1'b1, 20'h00FF0, 8'h00);
    do_op(1'b0, 20'h00FF0, 8'h00);

    // R7: request held high with changing operands through the whole write.
    wr0 = wr_cnt; rd0 = rd_cnt;
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 20'hCAFE0; req_wdata = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    req_we = 1'b0; req_addr = 20'h0BEEF; req_wdata = 8'hC3;
    for (int k = 0; k < 40 && !wdone; k++) begin
      chk(ram_addr == 20'hCAFE0, "R7", "held request address", ram_addr, 20'hCAFE0);
      @(negedge clk);
    end
    req = 1'b0;
    exp_mem[20'hCAFE0] = 8'h3C;
    prev_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_cnt - wr0 == 1, "R7", "writes during held request", wr_cnt - wr0, 1);
    chk(rd_cnt - rd0 == 0, "R7", "reads during held request", rd_cnt - rd0, 0);
    do_op(1'b0, 20'hCAFE0, 8'h00);
    do_op(1'b0, 20'h0BEEF, 8'h00);

    repeat (3) @(negedge clk);
    chk(ovl_bad == 0, "R8", "cycles with both strobes low", ovl_bad, 0);
    chk(stby_bad == 0, "R9", "idle cycles not in standby", stby_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule